// File: doc/BRIEF.md
# Pseudo-Associative Read Cache

This block is a read-only cache that keeps the single-probe cost of a direct-mapped lookup while removing many conflict misses. Its index space is split into two halves. Every line address has a primary slot, which is the ordinary direct-mapped index. It also has a partner slot, found by flipping the most significant index bit.

An access is resolved in one of three ways, each with its own latency:

- A match in the primary slot answers in one cycle.
- A match in the partner slot, checked one cycle later, answers in two cycles and is called a pseudo-hit.
- A mismatch in both slots requests the word from the next memory level. The access completes once that level returns it.

The CPU side uses a valid/ready handshake. Ready drops for the whole of any slow access. Lines move between the two slots so that the most recently used line sits in its primary slot.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset, ready is 1, rsp_valid is 0 and fill_req is 0. Every slot is invalid, so the first access to any address is a full miss.
- R2: A request accepted while the primary slot (index = req_addr[IDX_W-1:0]) holds the address gives rsp_valid in the cycle after the accepting edge, with no fill request.
- R3: When the primary slot misses, the partner slot (primary index with bit IDX_W-1 inverted) is checked. A match there gives rsp_valid two cycles after acceptance, with no fill request.
- R4: A pseudo-hit swaps the two slots. The next access to the same address is a fast hit, and the line that was displaced from the primary slot now answers as a pseudo-hit.
- R5: When both slots miss, fill_req rises in the second cycle after acceptance with fill_addr equal to the request address. Both hold steady until fill_valid is seen.
- R6: fill_valid sampled high while fill_req is high gives rsp_valid in the next cycle carrying fill_data, and fill_req drops in that same cycle. The miss latency is therefore 3 cycles plus the number of cycles the fill is held back.
- R7: On a fill, the new line goes into the primary slot and the previous primary line moves to the partner slot. The previous partner line is discarded.
- R8: ready is 0 in every cycle between the acceptance of a slow access and its response. ready is 1 whenever rsp_valid is 1.
- R9: Each stored tag includes the top index bit. A slot never matches an address that differs from its line only in that bit.
- R10: rsp_data always equals the word last fetched from memory for the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU read request, taken when ready is 1 |
| req_addr | input | ADDR_W | Word address of the request |
| ready | output | 1 | Cache can accept a request this cycle |
| rsp_valid | output | 1 | Response word valid (one cycle) |
| rsp_data | output | DATA_W | Response word |
| fill_req | output | 1 | Request to the next memory level |
| fill_addr | output | ADDR_W | Address being fetched |
| fill_valid | input | 1 | Fetched word is present |
| fill_data | input | DATA_W | Fetched word |

## Verification
A wrong tag, valid bit or slot move does not corrupt data at the moment it happens. It shows up as a wrong latency on a later access to the same pair of slots. For example, a missing swap turns the next expected fast hit into a pseudo-hit, and a wrong placement turns an expected pseudo-hit into a full miss with a visible fill request. For this reason every access in the bench measures its latency exactly and checks the presence of a fill, as well as the data. Sequences of accesses are built so that each move of a slot is observed within one or two accesses after it happens.

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int SETS = 1 << IDX_W;
  localparam int ID_W = ADDR_W - IDX_W + 1;
  localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_ALT, S_FILL} state_t;
  state_t state;

  logic [SETS-1:0]   vld;
  logic [ID_W-1:0]   tags  [SETS];
  logic [DATA_W-1:0] lines [SETS];
  logic [ADDR_W-1:0] held;

  wire [IDX_W-1:0] p_idx  = req_addr[IDX_W-1:0];
  wire [ID_W-1:0]  p_id   = req_addr[ADDR_W-1:IDX_W-1];
  wire [IDX_W-1:0] h_idx  = held[IDX_W-1:0];
  wire [IDX_W-1:0] h_alt  = h_idx ^ FLIP;
  wire [ID_W-1:0]  h_id   = held[ADDR_W-1:IDX_W-1];

  wire fast_hit = vld[p_idx] && (tags[p_idx] == p_id);
  wire alt_hit  = vld[h_alt] && (tags[h_alt] == h_id);
  wire do_swap  = (state == S_ALT) && alt_hit;
  wire do_fill  = (state == S_FILL) && fill_valid;

  assign ready     = (state == S_IDLE);
  assign fill_req  = (state == S_FILL);
  assign fill_addr = held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      held      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          held <= req_addr;
          if (fast_hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= lines[p_idx];
          end else begin
            state <= S_ALT;
          end
        end
        S_ALT: if (alt_hit) begin
          rsp_valid <= 1'b1;
          rsp_data  <= lines[h_alt];
          state     <= S_IDLE;
        end else begin
          state <= S_FILL;
        end
        S_FILL: if (fill_valid) begin
          rsp_valid <= 1'b1;
          rsp_data  <= fill_data;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (do_swap) begin
      vld[h_idx] <= 1'b1;
      vld[h_alt] <= vld[h_idx];
    end else if (do_fill) begin
      vld[h_idx] <= 1'b1;
      vld[h_alt] <= vld[h_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (do_swap) begin
      tags[h_idx]  <= tags[h_alt];
      tags[h_alt]  <= tags[h_idx];
      lines[h_idx] <= lines[h_alt];
      lines[h_alt] <= lines[h_idx];
    end else if (do_fill) begin
      tags[h_alt]  <= tags[h_idx];
      lines[h_alt] <= lines[h_idx];
      tags[h_idx]  <= h_id;
      lines[h_idx] <= fill_data;
    end
  end
endmodule

module pseudo_assoc_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              fill_req,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              fill_valid,
  input logic [DATA_W-1:0] fill_data
);
  a_r5_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_valid |=> fill_req && $stable(fill_addr));
  a_r6_fill_answer: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && fill_valid |=> rsp_valid && !fill_req && rsp_data == $past(fill_data));
  a_r8_fill_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !ready);
  a_r8_resp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ready);
  a_r2_answer_or_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ready && req_valid |=> rsp_valid || !ready);
  a_r3_no_early_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ready && req_valid |=> !fill_req);
endmodule

bind pseudo_assoc_cache pseudo_assoc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fill_req(fill_req),
  .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data)
);

// File: tb/sim_pseudo_assoc_cache.sv
module sim_pseudo_assoc_cache;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic ready, rsp_valid, fill_req;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] fill_addr;
  logic fill_valid = 1'b0;
  logic [DW-1:0] fill_data = '0;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pseudo_assoc_cache #(.ADDR_W(AW), .IDX_W(4), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .ready(ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a, 8'h5A, ~a};
  endfunction

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // kind: 0 fast hit, 1 pseudo-hit, 2 miss
  task automatic access(input logic [AW-1:0] a, input int kind, input int wait_n, input string rq);
    int lat = 1;
    int waited = 0;
    bit fill_seen = 0;
    bit stall_ok = 1;
    bit addr_ok = 1;
    int exp_lat = (kind == 0) ? 1 : (kind == 1) ? 2 : 3 + wait_n;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && lat < 60) begin
      if (ready) stall_ok = 0;
      if (fill_req) begin
        fill_seen = 1;
        if (fill_addr != a) addr_ok = 0;
        if (waited == wait_n) begin
          fill_valid = 1'b1;
          fill_data  = word_of(a);
        end else waited++;
      end
      @(negedge clk);
      fill_valid = 1'b0;
      lat++;
    end
    check(lat == exp_lat, rq, 64'(lat), 64'(exp_lat));
    check(rsp_data == word_of(a), "R10 data", 64'(rsp_data), 64'(word_of(a)));
    check(fill_seen == (kind == 2), "R5 fill presence", 64'(fill_seen), 64'(kind == 2));
    if (kind == 2) check(addr_ok, "R5 fill address", 64'(addr_ok), 64'd1);
    if (kind != 0) check(stall_ok, "R8 ready low while slow", 64'(stall_ok), 64'd1);
    check(ready, "R8 ready with response", 64'(ready), 64'd1);
  endtask

  task automatic t_reset();
    check(ready == 1'b1, "R1 ready", 64'(ready), 64'd1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check(fill_req == 1'b0, "R1 fill_req", 64'(fill_req), 64'd0);
  endtask

  task automatic t_cold_and_fast();
    access(12'h120, 2, 0, "R1 cold miss latency");
    access(12'h120, 0, 0, "R2 fast hit latency");
    access(12'h120, 0, 0, "R2 repeated fast hit");
  endtask

  task automatic t_pseudo_swap();
    access(12'h340, 2, 2, "R6 delayed fill latency");
    access(12'h120, 1, 0, "R3 pseudo-hit latency");
    access(12'h120, 0, 0, "R4 fast after swap");
    access(12'h340, 1, 0, "R4 displaced line pseudo-hit");
  endtask

  task automatic t_placement();
    access(12'h560, 2, 0, "R7 new line miss");
    access(12'h120, 2, 1, "R7 old partner evicted");
    access(12'h560, 1, 0, "R7 old primary kept in partner");
  endtask

  task automatic t_alias();
    access(12'h128, 2, 0, "R9 top index bit alias misses");
    access(12'h120, 0, 0, "R9 original line in moved slot");
    access(12'h128, 0, 0, "R9 alias now fast");
  endtask

  initial begin
    #(8 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_and_fast();
    t_pseudo_swap();
    t_placement();
    t_alias();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule